// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This controller carries out a complete dynamic reconfiguration of a PLL through its byte-wide register port. A host places a list of register updates on the request pins and pulses `start`. Each update has a base address, a 32-bit value and a 32-bit mask, for example a new setting for an output counter. The sequencer then works through a fixed order of steps. It sets the reconfiguration-enable bit. It applies each listed update. It puts the PLL into reset and takes it out again. As its last step it triggers recalibration. While the steps run it holds `busy`, and it pulses `done` when they are finished.

Every change on the register port is a read-modify-write of one byte. The sequencer reads the byte, replaces only the bits selected by the mask, and writes the merged byte back. A 32-bit register at base address A is laid out little-endian on the port: byte lane j of the value and of the mask belongs to address A+j. The register port is a simple master with address, read, write, write data, read data and waitrequest. A command is held until waitrequest is low. Read data is taken in the cycle in which the read completes.

Inside the block, the step sequencer passes each byte operation to the access engine over a valid/ready handshake. The sequencer holds the operation stable while ready is low. The engine accepts an operation only while no access is in flight.

Top module: `pll_reconfig_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and 1 <= `req_count` <= N_ENTRIES. After an accepted start, `busy` is high in the next cycle. A start with a count of 0, or with a count above N_ENTRIES, is ignored: `busy` stays low and no register access takes place.
- R2: The register writes of one run appear in this fixed order. First the enable write. Then the writes for the listed entries, taken in index order, with byte lanes in ascending address order within each entry. Then the reset-set write, the reset-clear write, and finally the recalibration write.
- R3: Every write is preceded by a read of the same address, and no other access comes between them. The written byte equals (read & ~mask) | (value & mask), using that address's byte lane of the entry's value and mask.
- R4: A byte lane whose mask byte is zero gets no access at all. An entry whose whole mask is zero therefore produces no accesses.
- R5: The fixed steps are the following. Enable sets bit 0 of the byte at 0x10. Reset sets bit 2 of the byte at 0x80, and release clears that same bit. Recalibration sets bit 3 of the byte at 0x89, which is bit 11 of the 32-bit register at 0x88. All other bits of these bytes keep the values that were read.
- R6: While `pll_waitreq` is high, the pending command, its address and its write data stay unchanged. An access completes in the first cycle in which `pll_waitreq` is low.
- R7: `pll_read` and `pll_write` are never high in the same cycle.
- R8: `busy` stays high until the recalibration write completes. In the next cycle `busy` is low and `done` is high, and `done` is high for that one cycle only.
- R9: While `busy` is high, a further `start` is ignored. The entry list is captured when the start is accepted, so later changes on the request pins have no effect on the run.
- R10: The synchronous reset `rst` returns the block to idle, even in the middle of a run. After the reset cycle, `busy` and `done` are low and no read or write is issued until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run a sequence |
| req_count | input | CNT_W | Number of valid entries, 1..N_ENTRIES |
| req_addr | input | N_ENTRIES*ADDR_W | Entry base addresses, entry e at bits [e*ADDR_W +: ADDR_W] |
| req_val | input | N_ENTRIES*32 | Entry values, entry e at bits [e*32 +: 32] |
| req_mask | input | N_ENTRIES*32 | Entry masks, where a 1 selects a bit to replace |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| pll_addr | output | ADDR_W | Register port byte address |
| pll_read | output | 1 | Read command |
| pll_write | output | 1 | Write command |
| pll_wdata | output | 8 | Write data |
| pll_rdata | input | 8 | Read data, valid in the cycle the read completes |
| pll_waitreq | input | 1 | Stalls the current command while high |

## Verification
Some rules are checked by the embedded properties on every clock cycle. These are the exclusivity of read and write, the stability of a stalled command, the order of the sequencer's phases, the single-cycle `done`, and the quiet bus after reset. Other behaviour can only be shown by the bench's scenarios against a byte-addressed register model. This covers the exact written bytes under masked merging, the skipping of zero-mask lanes, and the treatment of out-of-range counts. It also covers the immunity to request changes during a run and recovery after a reset in the middle of a sequence.

// File: rtl/pll_rcfg_pkg.sv
package pll_rcfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ENABLE  = 3'd1,
    PH_PROG    = 3'd2,
    PH_RST_SET = 3'd3,
    PH_RST_CLR = 3'd4,
    PH_RECAL   = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    AX_IDLE  = 2'd0,
    AX_READ  = 2'd1,
    AX_WRITE = 2'd2
  } axs_t;

  localparam int unsigned LANE_BITS = 8;

  // fixed control bytes: address, bit pattern to apply
  localparam logic [7:0] ENA_BYTE_ADDR = 8'h10;
  localparam logic [7:0] ENA_BIT       = 8'h01;
  localparam logic [7:0] RST_BYTE_ADDR = 8'h80;
  localparam logic [7:0] RST_BIT       = 8'h04;
  localparam logic [7:0] CAL_BYTE_ADDR = 8'h89;
  localparam logic [7:0] CAL_BIT       = 8'h08;

endpackage

// File: rtl/pll_rcfg_entries.sv
module pll_rcfg_entries #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned ENT_W     = 2,
  parameter int unsigned LANE_W    = 2
) (
  input  logic                          clk,
  input  logic                          load,
  input  logic [N_ENTRIES*ADDR_W-1:0]   in_addr,
  input  logic [N_ENTRIES*REG_W-1:0]    in_val,
  input  logic [N_ENTRIES*REG_W-1:0]    in_mask,
  input  logic [ENT_W-1:0]              sel_ent,
  input  logic [LANE_W-1:0]             sel_lane,
  output logic [ADDR_W-1:0]             lane_addr,
  output logic [7:0]                    lane_val,
  output logic [7:0]                    lane_mask
);

  logic [ADDR_W-1:0] addr_q [N_ENTRIES];
  logic [REG_W-1:0]  val_q  [N_ENTRIES];
  logic [REG_W-1:0]  mask_q [N_ENTRIES];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (load) begin
        addr_q[e] <= in_addr[e*ADDR_W +: ADDR_W];
        val_q[e]  <= in_val[e*REG_W +: REG_W];
        mask_q[e] <= in_mask[e*REG_W +: REG_W];
      end
    end
  end

  always_comb begin
    lane_addr = addr_q[sel_ent] + ADDR_W'(sel_lane);
    lane_val  = val_q[sel_ent][sel_lane*8 +: 8];
    lane_mask = mask_q[sel_ent][sel_lane*8 +: 8];
  end

endmodule

// File: rtl/pll_rcfg_rmw.sv
module pll_rcfg_rmw
  import pll_rcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_val,
  input  logic [7:0]        op_mask,
  output logic              op_done,
  output logic [ADDR_W-1:0] pll_addr,
  output logic              pll_read,
  output logic              pll_write,
  output logic [7:0]        pll_wdata,
  input  logic [7:0]        pll_rdata,
  input  logic              pll_waitreq
);

  axs_t              st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        val_q;
  logic [7:0]        mask_q;
  logic [7:0]        merged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= AX_IDLE;
      addr_q   <= '0;
      val_q    <= '0;
      mask_q   <= '0;
      merged_q <= '0;
    end else begin
      unique case (st_q)
        AX_IDLE: if (op_valid) begin
          addr_q <= op_addr;
          val_q  <= op_val;
          mask_q <= op_mask;
          st_q   <= AX_READ;
        end
        AX_READ: if (!pll_waitreq) begin
          merged_q <= (pll_rdata & ~mask_q) | (val_q & mask_q);
          st_q     <= AX_WRITE;
        end
        AX_WRITE: if (!pll_waitreq) st_q <= AX_IDLE;
        default: st_q <= AX_IDLE;
      endcase
    end
  end

  assign op_ready  = (st_q == AX_IDLE);
  assign op_done   = (st_q == AX_WRITE) && !pll_waitreq;
  assign pll_addr  = addr_q;
  assign pll_read  = (st_q == AX_READ);
  assign pll_write = (st_q == AX_WRITE);
  assign pll_wdata = merged_q;

  // R7
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pll_read && pll_write));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_read && pll_waitreq) |=> (pll_read && $stable(pll_addr)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_write && pll_waitreq) |=> (pll_write && $stable(pll_addr) && $stable(pll_wdata)));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_read && !pll_waitreq) |=> (pll_write && $stable(pll_addr)));

  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pll_read && !pll_write));

endmodule

// File: rtl/pll_rcfg_ctrl.sv
module pll_rcfg_ctrl
  import pll_rcfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned ENT_W     = 2,
  parameter int unsigned LANE_W    = 2,
  parameter int unsigned LANES     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  req_count,
  output logic              load,
  output logic [ENT_W-1:0]  sel_ent,
  output logic [LANE_W-1:0] sel_lane,
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic [7:0]        lane_val,
  input  logic [7:0]        lane_mask,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_val,
  output logic [7:0]        op_mask,
  input  logic              op_done,
  output logic              busy,
  output logic              done
);

  phase_t            phase_q, nxt_phase;
  logic              issued_q;
  logic [ENT_W-1:0]  ent_q, nxt_ent, last_q;
  logic [LANE_W-1:0] lane_q, nxt_lane;
  logic              busy_q, done_q, fin;
  logic              start_ok, skip_lane, advance;

  assign start_ok = start && !busy_q && (req_count != '0) &&
                    (req_count <= CNT_W'(N_ENTRIES));
  assign load     = start_ok;
  assign sel_ent  = ent_q;
  assign sel_lane = lane_q;

  // operation presented to the access engine
  always_comb begin
    op_addr = lane_addr;
    op_val  = lane_val;
    op_mask = lane_mask;
    unique case (phase_q)
      PH_ENABLE:  begin op_addr = ADDR_W'(ENA_BYTE_ADDR); op_val = ENA_BIT; op_mask = ENA_BIT; end
      PH_RST_SET: begin op_addr = ADDR_W'(RST_BYTE_ADDR); op_val = RST_BIT; op_mask = RST_BIT; end
      PH_RST_CLR: begin op_addr = ADDR_W'(RST_BYTE_ADDR); op_val = 8'h00;   op_mask = RST_BIT; end
      PH_RECAL:   begin op_addr = ADDR_W'(CAL_BYTE_ADDR); op_val = CAL_BIT; op_mask = CAL_BIT; end
      default: ;
    endcase
  end

  assign skip_lane = (phase_q == PH_PROG) && !issued_q && (lane_mask == 8'h00);
  assign op_valid  = (phase_q != PH_IDLE) && !issued_q && !skip_lane;
  assign advance   = op_done || skip_lane;

  // successor of the current step
  always_comb begin
    nxt_phase = phase_q;
    nxt_ent   = ent_q;
    nxt_lane  = lane_q;
    fin       = 1'b0;
    unique case (phase_q)
      PH_ENABLE:  nxt_phase = PH_PROG;
      PH_PROG: begin
        if (lane_q == LANE_W'(LANES - 1)) begin
          nxt_lane = '0;
          if (ent_q == last_q) nxt_phase = PH_RST_SET;
          else                 nxt_ent   = ent_q + 1'b1;
        end else begin
          nxt_lane = lane_q + 1'b1;
        end
      end
      PH_RST_SET: nxt_phase = PH_RST_CLR;
      PH_RST_CLR: nxt_phase = PH_RECAL;
      PH_RECAL: begin
        nxt_phase = PH_IDLE;
        fin       = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      issued_q <= 1'b0;
      ent_q    <= '0;
      lane_q   <= '0;
      last_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_ok) begin
          phase_q  <= PH_ENABLE;
          busy_q   <= 1'b1;
          ent_q    <= '0;
          lane_q   <= '0;
          issued_q <= 1'b0;
          last_q   <= ENT_W'(req_count - 1'b1);
        end
      end else begin
        if (op_valid && op_ready) issued_q <= 1'b1;
        if (advance) begin
          issued_q <= 1'b0;
          phase_q  <= nxt_phase;
          ent_q    <= nxt_ent;
          lane_q   <= nxt_lane;
          if (fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && phase_q == PH_IDLE));

  // R2
  prog_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PROG) |=> (phase_q == PH_PROG || phase_q == PH_RST_SET));

  // R2
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RST_CLR) |=> (phase_q == PH_RST_CLR || phase_q == PH_RECAL));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && phase_q != PH_RECAL) |=> busy);

  // R10
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done));

endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pll_rcfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_W     = 32,
  localparam int unsigned CNT_W    = $clog2(N_ENTRIES + 1),
  localparam int unsigned ENT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int unsigned LANES    = REG_W / LANE_BITS,
  localparam int unsigned LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [CNT_W-1:0]            req_count,
  input  logic [N_ENTRIES*ADDR_W-1:0] req_addr,
  input  logic [N_ENTRIES*REG_W-1:0]  req_val,
  input  logic [N_ENTRIES*REG_W-1:0]  req_mask,
  output logic                        busy,
  output logic                        done,
  output logic [ADDR_W-1:0]           pll_addr,
  output logic                        pll_read,
  output logic                        pll_write,
  output logic [7:0]                  pll_wdata,
  input  logic [7:0]                  pll_rdata,
  input  logic                        pll_waitreq
);

  logic              load;
  logic [ENT_W-1:0]  sel_ent;
  logic [LANE_W-1:0] sel_lane;
  logic [ADDR_W-1:0] lane_addr, op_addr;
  logic [7:0]        lane_val, lane_mask, op_val, op_mask;
  logic              op_valid, op_ready, op_done;

  pll_rcfg_entries #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .REG_W(REG_W),
    .ENT_W(ENT_W), .LANE_W(LANE_W)
  ) u_entries (
    .clk(clk), .load(load),
    .in_addr(req_addr), .in_val(req_val), .in_mask(req_mask),
    .sel_ent(sel_ent), .sel_lane(sel_lane),
    .lane_addr(lane_addr), .lane_val(lane_val), .lane_mask(lane_mask)
  );

  pll_rcfg_ctrl #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .ENT_W(ENT_W), .LANE_W(LANE_W), .LANES(LANES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .req_count(req_count),
    .load(load), .sel_ent(sel_ent), .sel_lane(sel_lane),
    .lane_addr(lane_addr), .lane_val(lane_val), .lane_mask(lane_mask),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_addr(op_addr), .op_val(op_val), .op_mask(op_mask),
    .op_done(op_done), .busy(busy), .done(done)
  );

  pll_rcfg_rmw #(.ADDR_W(ADDR_W)) u_rmw (
    .clk(clk), .rst(rst),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_addr(op_addr), .op_val(op_val), .op_mask(op_mask), .op_done(op_done),
    .pll_addr(pll_addr), .pll_read(pll_read), .pll_write(pll_write),
    .pll_wdata(pll_wdata), .pll_rdata(pll_rdata), .pll_waitreq(pll_waitreq)
  );

endmodule

// File: tb/tb_pll_reconfig_seq.sv
module tb_pll_reconfig_seq;

  localparam int N = 4;

  typedef struct packed {
    logic [2:0]  cnt;
    logic [1:0]  stall;
    logic [7:0]  a0;
    logic [31:0] v0;
    logic [31:0] m0;
    logic [7:0]  a1;
    logic [31:0] v1;
    logic [31:0] m1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd1, 2'd0, 8'h5C, 32'h0F00081E, 32'hFFFFFFFF, 8'h00, 32'h0, 32'h0},
    '{3'd2, 2'd2, 8'h60, 32'h00001234, 32'h0000FFFF, 8'h64, 32'hAB000000, 32'hFF000000},
    '{3'd2, 2'd1, 8'h5C, 32'hA5A5A5A5, 32'h0F0F0F0F, 8'h70, 32'h12345678, 32'h00000000},
    '{3'd1, 2'd3, 8'h10, 32'hFFFFFFFE, 32'h000000FE, 8'h00, 32'h0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] req_count = '0;
  logic [N*8-1:0]  req_addr;
  logic [N*32-1:0] req_val, req_mask;
  logic busy, done, pll_read, pll_write, pll_waitreq;
  logic [7:0] pll_addr, pll_wdata, pll_rdata;

  logic [7:0]  rq_a [N];
  logic [31:0] rq_v [N];
  logic [31:0] rq_m [N];

  always #10 clk = ~clk;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      req_addr[e*8 +: 8]   = rq_a[e];
      req_val[e*32 +: 32]  = rq_v[e];
      req_mask[e*32 +: 32] = rq_m[e];
    end
  end

  pll_reconfig_seq dut (
    .clk(clk), .rst(rst), .start(start), .req_count(req_count),
    .req_addr(req_addr), .req_val(req_val), .req_mask(req_mask),
    .busy(busy), .done(done),
    .pll_addr(pll_addr), .pll_read(pll_read), .pll_write(pll_write),
    .pll_wdata(pll_wdata), .pll_rdata(pll_rdata), .pll_waitreq(pll_waitreq)
  );

  // register model
  logic [7:0] mem [256];
  int stall = 0;
  int wcnt = 0;
  logic [7:0] log_a [64];
  logic [7:0] log_d [64];
  int logc = 0;
  int acc_cnt = 0;
  int rw_err = 0;
  logic [7:0] last_rd = '0;
  logic rd_ok = 1'b0;

  assign pll_rdata   = mem[pll_addr];
  assign pll_waitreq = (pll_read || pll_write) && (wcnt < stall);

  always @(posedge clk) begin
    if (rst) begin
      wcnt  = 0;
      rd_ok = 1'b0;
    end else begin
      if ((pll_read || pll_write) && pll_waitreq) wcnt = wcnt + 1;
      else wcnt = 0;
      if (pll_read && !pll_waitreq) begin
        last_rd = pll_addr;
        rd_ok   = 1'b1;
        acc_cnt++;
      end
      if (pll_write && !pll_waitreq) begin
        if (!rd_ok || last_rd != pll_addr) rw_err++;
        rd_ok = 1'b0;
        mem[pll_addr] = pll_wdata;
        if (logc < 64) begin
          log_a[logc] = pll_addr;
          log_d[logc] = pll_wdata;
        end
        logc++;
        acc_cnt++;
      end
    end
  end

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected model
  logic [7:0] exp_mem [256];
  logic [7:0] ex_a [64];
  logic [7:0] ex_d [64];
  int exc;

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 29 + 7);
      exp_mem[i] = 8'(i * 29 + 7);
    end
    logc = 0;
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] v, input logic [7:0] m);
    exp_mem[a] = (exp_mem[a] & ~m) | (v & m);
    ex_a[exc] = a;
    ex_d[exc] = exp_mem[a];
    exc++;
  endtask

  task automatic build_exp(input int cnt);
    exc = 0;
    push(8'h10, 8'h01, 8'h01);
    for (int e = 0; e < cnt; e++)
      for (int j = 0; j < 4; j++)
        if (rq_m[e][j*8 +: 8] != 8'h00)
          push(8'(rq_a[e] + j), rq_v[e][j*8 +: 8], rq_m[e][j*8 +: 8]);
    push(8'h80, 8'h04, 8'h04);
    push(8'h80, 8'h00, 8'h04);
    push(8'h89, 8'h08, 8'h08);
  endtask

  task automatic pulse_start(input logic [2:0] cnt);
    @(negedge clk);
    req_count = cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, req, 32'(seen), 32'd1);
  endtask

  task automatic compare_run();
    bit same = 1'b1;
    chk(logc == exc, "R2 R4 write count", 32'(logc), 32'(exc));
    for (int k = 0; k < exc && k < logc; k++) begin
      chk(log_a[k] == ex_a[k], "R2 write order address", 32'(log_a[k]), 32'(ex_a[k]));
      chk(log_d[k] == ex_d[k], "R3 R5 merged write data", 32'(log_d[k]), 32'(ex_d[k]));
    end
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) same = 1'b0;
    chk(same, "R3 R5 register image", 32'(same), 32'd1);
  endtask

  task automatic full_run(input logic [2:0] cnt, input int st);
    bit seen;
    init_mem();
    stall = st;
    build_exp(cnt);
    pulse_start(cnt);
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    wait_done("R8 done reached", seen);
    chk(busy == 1'b0, "R8 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
    compare_run();
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit seen;
    int snap;
    int active;
    for (int e = 0; e < N; e++) begin rq_a[e] = '0; rq_v[e] = '0; rq_m[e] = '0; end
    init_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !pll_read && !pll_write, "R10 reset state",
        {busy, done, pll_read, pll_write}, 32'd0);

    // table of vectors
    for (int i = 0; i < 4; i++) begin
      rq_a[0] = VECS[i].a0; rq_v[0] = VECS[i].v0; rq_m[0] = VECS[i].m0;
      rq_a[1] = VECS[i].a1; rq_v[1] = VECS[i].v1; rq_m[1] = VECS[i].m1;
      full_run(VECS[i].cnt, int'(VECS[i].stall));
    end

    // R1 count zero and count above limit ignored
    snap = acc_cnt;
    pulse_start(3'd0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R1 zero count ignored", 32'(busy), 32'd0);
    pulse_start(3'd5);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R1 over-limit count ignored", 32'(busy), 32'd0);
    chk(acc_cnt == snap, "R1 no access on rejected start", 32'(acc_cnt), 32'(snap));

    // R1 R9 full list of N entries; inputs changed and start repeated mid-run
    for (int e = 0; e < N; e++) begin
      rq_a[e] = 8'(8'h40 + e * 8);
      rq_v[e] = 32'h11223344 * (e + 1);
      rq_m[e] = 32'hF0F0F0F0 >> e;
    end
    init_mem();
    stall = 1;
    build_exp(N);
    pulse_start(3'(N));
    chk(busy == 1'b1, "R1 max count accepted", 32'(busy), 32'd1);
    repeat (10) @(negedge clk);
    rq_a[0] = 8'hC0; rq_v[0] = 32'hFFFFFFFF; rq_m[0] = 32'hFFFFFFFF;
    start = 1'b1; req_count = 3'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9 run completes", seen);
    @(negedge clk);
    chk(busy == 1'b0, "R9 no restart after ignored start", 32'(busy), 32'd0);
    compare_run();
    chk(rw_err == 0, "R3 read precedes write", 32'(rw_err), 32'd0);

    // R10 reset in the middle of a run
    rq_a[0] = 8'h5C; rq_v[0] = 32'h0F00081E; rq_m[0] = 32'hFFFFFFFF;
    init_mem();
    stall = 2;
    pulse_start(3'd1);
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R10 idle after mid-run reset", {busy, done}, 32'd0);
    active = 0;
    for (int t = 0; t < 10; t++) begin
      if (pll_read || pll_write) active++;
      @(negedge clk);
    end
    chk(active == 0, "R10 bus quiet after reset", 32'(active), 32'd0);

    // R10 recovery: a fresh run behaves normally
    rq_a[0] = VECS[0].a0; rq_v[0] = VECS[0].v0; rq_m[0] = VECS[0].m0;
    rw_err = 0;
    full_run(3'd1, 0);
    chk(rw_err == 0, "R3 read precedes write after reset", 32'(rw_err), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule